// File: doc/BRIEF.md
# Expansion ROM Base Register and Window Decoder

This block is the slice of a PCI function's configuration header that controls an expansion ROM, together with the memory-space decoder for that ROM. System software writes the base register through a dword-wide configuration port with per-byte enables. It can first write all ones and read back to learn how large a window the function needs, then place the window and turn it on. Configuration writes that fall on the other base-register offsets of the header are dropped.

Memory reads of one, two or four bytes are decoded lane by lane. Each lane whose byte address falls inside an enabled window returns the matching byte of an internal ROM array, with the lowest address on the lowest lane. A lane outside the window, or any lane while the window is off, returns 0xFF. Memory writes that land in the window are claimed and then thrown away. The ROM array is sized from the image length, rounded up to a power of two. A testbench fills the array through a separate backdoor write port.

Top module: `xrom_bar_dec`

## Requirements
- R1: After synchronous reset the base register reads 0x00000000 at dword index 12 (byte offset 0x30), so the enable bit is clear and no access is claimed.
- R2: A write to dword index 12 stores only the writable bits. Bit 0 is the enable. Bits 9:1 and every address bit below log2 of the window size read as zero. With the default window of 2048 bytes, writing 0xFFFFFFFF reads back 0xFFFFF801, and writing 0x000C03FF reads back 0x000C0001.
- R3: Bit k of `cfg_be` selects whether byte k (bits 8k+7:8k) of the base register takes the new value. Bytes whose enable is low keep their old value.
- R4: Configuration writes to dword indices 5 through 11 (byte offsets 0x14 to 0x2F) leave the base register unchanged.
- R5: While the enable bit is clear, `mem_hit` stays low and every requested lane of `mem_rdata` reads 0xFF.
- R6: The window size is the smallest power of two that is at least `IMG_BYTES`. With the default 1536-byte image this is 2048 bytes. A lane whose address A satisfies base <= A < base + window, with enable set, returns ROM byte A - base.
- R7: Lane i of `mem_rdata` (bits 8i+7:8i) carries the byte at `mem_addr` + i, in little-endian order.
- R8: A requested lane whose address lies outside the window returns 0xFF, even when other lanes of the same access hit.
- R9: A memory write (`mem_wr`) that falls in the enabled window raises `mem_hit` and leaves the ROM contents unchanged.
- R10: `mem_len` encodes the access width: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 gives 4 bytes. Lanes at or above the width read 0x00.
- R11: Configuration reads at any dword index other than 12 return 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Per-byte write enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_dw` (combinational) |
| mem_rd | input | 1 | Memory read request |
| mem_wr | input | 1 | Memory write request (data discarded) |
| mem_addr | input | 32 | Byte address of lane 0 |
| mem_len | input | 2 | Access width code |
| mem_rdata | output | 32 | Read data, little-endian lanes (combinational) |
| mem_hit | output | 1 | Access claimed by the ROM window |
| bd_we | input | 1 | Backdoor ROM write strobe |
| bd_addr | input | AW | Backdoor ROM byte address |
| bd_data | input | 8 | Backdoor ROM byte |

## Verification
The assertions assume that every input is held stable across a clock edge, and that reset stays high for at least one edge before the first configuration write. They also assume `mem_rd` and `mem_wr` are never asserted together. The bench changes every input only on the falling edge, holds reset for several cycles, and issues one kind of memory request at a time. The backdoor port is used only during setup, before the window is enabled, so the ROM contents are fixed while reads are checked.

// File: rtl/xrom_pkg.sv
package xrom_pkg;

    localparam int unsigned ROM_DW_IDX  = 12;   // dword index of the ROM base register
    localparam int unsigned GAP_DW_LO   = 5;    // first ignored dword index
    localparam int unsigned GAP_DW_HI   = 11;   // last ignored dword index
    localparam int unsigned LANES       = 4;
    localparam logic [31:0] FIXED_MASK  = 32'hFFFF_FC01;

    typedef enum logic [1:0] {
        LEN_BYTE  = 2'd0,
        LEN_HALF  = 2'd1,
        LEN_WORD  = 2'd2,
        LEN_WORDX = 2'd3
    } mem_len_e;

    typedef struct packed {
        logic [31:0] base;
        logic        en;
    } win_view_t;

    function automatic int unsigned pow2_ceil(input int unsigned n);
        int unsigned p;
        p = 1;
        for (int i = 0; i < 20; i++) begin
            if (p < n) p = p << 1;
        end
        return p;
    endfunction

    function automatic logic [31:0] bar_wmask(input int unsigned win);
        logic [31:0] w;
        w = 32'(win);
        return (~(w - 32'd1) & FIXED_MASK) | 32'h1;
    endfunction

    function automatic logic [LANES-1:0] lane_map(input logic [1:0] code);
        case (mem_len_e'(code))
            LEN_BYTE: return 4'b0001;
            LEN_HALF: return 4'b0011;
            default:  return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/xrom_cfg_slice.sv
module xrom_cfg_slice
    import xrom_pkg::*;
#(
    parameter int unsigned WIN = 2048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dw,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic [31:0] bar_q
);
    localparam logic [31:0] WMASK = bar_wmask(WIN);

    logic        sel_bar;
    logic [31:0] masked;

    assign sel_bar = (cfg_dw == 6'(ROM_DW_IDX));
    assign masked  = cfg_wdata & WMASK;

    for (genvar b = 0; b < LANES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                bar_q[8*b +: 8] <= 8'h00;
            end else if (cfg_wr && sel_bar && cfg_be[b]) begin
                bar_q[8*b +: 8] <= masked[8*b +: 8];
            end
        end
    end

    assign cfg_rdata = sel_bar ? bar_q : 32'h0;

endmodule

// File: rtl/xrom_lane_dec.sv
module xrom_lane_dec #(
    parameter int unsigned WIN = 2048,
    parameter int unsigned AW  = 11
) (
    input  logic [31:0]   base,
    input  logic          en,
    input  logic          lane_on,
    input  logic [31:0]   lane_addr,
    output logic          hit,
    output logic [AW-1:0] idx
);
    localparam logic [31:0] PAGE = ~(32'(WIN) - 32'd1);

    assign hit = en && lane_on && ((lane_addr & PAGE) == (base & PAGE));
    assign idx = lane_addr[AW-1:0];

endmodule

// File: rtl/xrom_store.sv
module xrom_store #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned AW    = 11,
    parameter int unsigned PORTS = 4
) (
    input  logic                  clk,
    input  logic                  bd_we,
    input  logic [AW-1:0]         bd_addr,
    input  logic [7:0]            bd_data,
    input  logic [PORTS*AW-1:0]   rd_idx,
    output logic [PORTS*8-1:0]    rd_byte
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (bd_we) mem[bd_addr] <= bd_data;
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign rd_byte[8*p +: 8] = mem[rd_idx[AW*p +: AW]];
    end

endmodule

// File: rtl/xrom_bar_dec.sv
module xrom_bar_dec
    import xrom_pkg::*;
#(
    parameter int unsigned IMG_BYTES = 1536,
    localparam int unsigned WIN      = pow2_ceil(IMG_BYTES),
    localparam int unsigned AW       = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic [5:0]    cfg_dw,
    input  logic [3:0]    cfg_be,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          mem_rd,
    input  logic          mem_wr,
    input  logic [31:0]   mem_addr,
    input  logic [1:0]    mem_len,
    output logic [31:0]   mem_rdata,
    output logic          mem_hit,
    input  logic          bd_we,
    input  logic [AW-1:0] bd_addr,
    input  logic [7:0]    bd_data
);
    logic [31:0]         bar_q;
    win_view_t           win;
    logic [LANES-1:0]    lane_on;
    logic [LANES-1:0]    lane_hit;
    logic [LANES*AW-1:0] lane_idx;
    logic [LANES*8-1:0]  lane_byte;

    xrom_cfg_slice #(.WIN(WIN)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_dw    (cfg_dw),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bar_q     (bar_q)
    );

    assign win.base = {bar_q[31:1], 1'b0};
    assign win.en   = bar_q[0];
    assign lane_on  = lane_map(mem_len);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        xrom_lane_dec #(.WIN(WIN), .AW(AW)) u_dec (
            .base      (win.base),
            .en        (win.en),
            .lane_on   (lane_on[i]),
            .lane_addr (mem_addr + 32'(i)),
            .hit       (lane_hit[i]),
            .idx       (lane_idx[AW*i +: AW])
        );
        assign mem_rdata[8*i +: 8] = !lane_on[i] ? 8'h00 :
                                     lane_hit[i] ? lane_byte[8*i +: 8] : 8'hFF;
    end

    xrom_store #(.DEPTH(WIN), .AW(AW), .PORTS(LANES)) u_rom (
        .clk     (clk),
        .bd_we   (bd_we),
        .bd_addr (bd_addr),
        .bd_data (bd_data),
        .rd_idx  (lane_idx),
        .rd_byte (lane_byte)
    );

    assign mem_hit = (mem_rd || mem_wr) && (|lane_hit);

endmodule

// File: rtl/xrom_bar_dec_chk.sv
module xrom_bar_dec_chk #(
    parameter int unsigned WIN = 2048
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_wr,
    input logic [5:0]  cfg_dw,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_rdata,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [1:0]  mem_len,
    input logic [31:0] mem_rdata,
    input logic        mem_hit,
    input logic [31:0] bar_q
);
    localparam int unsigned LOWB = ($clog2(WIN) < 10) ? 10 : $clog2(WIN);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bar_q == 32'h0));

    p_low_bits_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_dw == 6'd12) |-> (cfg_rdata[LOWB-1:1] == '0));

    p_be_keeps_top_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_dw == 6'd12 && !cfg_be[3]) |=> (bar_q[31:24] == $past(bar_q[31:24])));

    p_gap_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_dw >= 6'd5 && cfg_dw <= 6'd11) |=> $stable(bar_q));

    p_off_no_hit_r5: assert property (@(posedge clk) disable iff (rst)
        !bar_q[0] |-> !mem_hit);

    p_off_ff_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !bar_q[0]) |-> (mem_rdata[7:0] == 8'hFF));

    p_idle_no_claim_r9: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd || mem_wr) |-> !mem_hit);

    p_idle_lanes_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_len == 2'd0) |-> (mem_rdata[31:8] == 24'h0));

    p_other_cfg_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_dw != 6'd12) |-> (cfg_rdata == 32'h0));

endmodule

bind xrom_bar_dec xrom_bar_dec_chk #(.WIN(WIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_dw    (cfg_dw),
    .cfg_be    (cfg_be),
    .cfg_rdata (cfg_rdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_len   (mem_len),
    .mem_rdata (mem_rdata),
    .mem_hit   (mem_hit),
    .bar_q     (bar_q)
);

// File: tb/sim_xrom_bar_dec.sv
module sim_xrom_bar_dec;
    localparam int AWT  = 11;
    localparam int WINT = 2048;
    localparam logic [31:0] BASE = 32'h000C_0000;
    localparam int NV = 9;
    localparam logic [31:0] V_ADDR [NV] = '{
        BASE, BASE + 32'd1, BASE + 32'h7FE, BASE + 32'h100, BASE + 32'h37,
        BASE - 32'd1, 32'h0, BASE + 32'h800, BASE + 32'h7FF
    };
    localparam logic [1:0] V_LEN [NV] = '{
        2'd2, 2'd3, 2'd2, 2'd1, 2'd0, 2'd2, 2'd2, 2'd0, 2'd1
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wr = 1'b0;
    logic [5:0] cfg_dw = 6'd0;
    logic [3:0] cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic mem_rd = 1'b0;
    logic mem_wr = 1'b0;
    logic [31:0] mem_addr = 32'h0;
    logic [1:0] mem_len = 2'd0;
    logic [31:0] mem_rdata;
    logic mem_hit;
    logic bd_we = 1'b0;
    logic [AWT-1:0] bd_addr = '0;
    logic [7:0] bd_data = 8'h0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xrom_bar_dec u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_rdata(mem_rdata), .mem_hit(mem_hit),
        .bd_we(bd_we), .bd_addr(bd_addr), .bd_data(bd_data)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + (a >> 5) + 7) & 255);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic cfg_read(input logic [5:0] dw, output logic [31:0] d);
        @(negedge clk);
        cfg_dw = dw;
        #2 d = cfg_rdata;
    endtask

    task automatic mem_read(input logic [31:0] a, input logic [1:0] len,
                            output logic [31:0] d, output logic h);
        @(negedge clk);
        mem_rd = 1'b1; mem_addr = a; mem_len = len;
        #2 d = cfg_rdata; d = mem_rdata; h = mem_hit;
        @(negedge clk);
        mem_rd = 1'b0;
    endtask

    function automatic void model(input logic [31:0] a, input logic [1:0] len, input bit en,
                                  input logic [31:0] base,
                                  output logic [31:0] d, output logic h);
        int n;
        n = (len == 2'd0) ? 1 : (len == 2'd1) ? 2 : 4;
        d = 32'h0; h = 1'b0;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] la;
            la = a + 32'(i);
            if (i >= n) d[8*i +: 8] = 8'h00;
            else if (en && la >= base && la < base + 32'(WINT)) begin
                d[8*i +: 8] = pat(int'(la - base));
                h = 1'b1;
            end else d[8*i +: 8] = 8'hFF;
        end
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, e;
        logic h, eh;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        cfg_read(6'd12, d);
        check("R1 reset base", d, 32'h0);
        mem_read(32'h0, 2'd2, d, h);
        check("R1 no claim after reset", {31'h0, h}, 32'h0);

        // R11: other offsets read zero
        cfg_read(6'd4, d);
        check("R11 other index", d, 32'h0);

        // load ROM through backdoor while window is off
        for (int i = 0; i < WINT; i++) begin
            @(negedge clk);
            bd_we = 1'b1; bd_addr = AWT'(i); bd_data = pat(i);
        end
        @(negedge clk);
        bd_we = 1'b0;

        // R2/R6: size probe
        cfg_write(6'd12, 4'hF, 32'hFFFF_FFFF);
        cfg_read(6'd12, d);
        check("R2 R6 size probe", d, 32'hFFFF_F801);

        // R4: gap writes ignored
        cfg_write(6'd11, 4'hF, 32'h0);
        cfg_write(6'd5, 4'hF, 32'h0);
        cfg_read(6'd12, d);
        check("R4 gap write ignored", d, 32'hFFFF_F801);

        // R3: byte enable selects byte 2 only
        cfg_write(6'd12, 4'b0100, 32'h0000_0000);
        cfg_read(6'd12, d);
        check("R3 byte lane write", d, 32'hFF00_F801);

        // R5: base placed, enable clear
        cfg_write(6'd12, 4'hF, BASE);
        mem_read(BASE, 2'd2, d, h);
        check("R5 disabled data", d, 32'hFFFF_FFFF);
        check("R5 disabled no hit", {31'h0, h}, 32'h0);

        // R2: bits 9:1 masked
        cfg_write(6'd12, 4'hF, BASE | 32'h3FF);
        cfg_read(6'd12, d);
        check("R2 low bits masked", d, BASE | 32'h1);

        // R6 R7 R8 R10: vector table
        for (int v = 0; v < NV; v++) begin
            mem_read(V_ADDR[v], V_LEN[v], d, h);
            model(V_ADDR[v], V_LEN[v], 1'b1, BASE, e, eh);
            check("R6 R7 R8 R10 read data", d, e);
            check("R6 R8 hit", {31'h0, h}, {31'h0, eh});
        end

        // R9: write claimed, contents unchanged
        @(negedge clk);
        mem_wr = 1'b1; mem_addr = BASE + 32'h10; mem_len = 2'd2;
        #2 check("R9 write claimed", {31'h0, mem_hit}, 32'h1);
        @(negedge clk);
        mem_wr = 1'b0;
        mem_read(BASE + 32'h10, 2'd2, d, h);
        model(BASE + 32'h10, 2'd2, 1'b1, BASE, e, eh);
        check("R9 contents unchanged", d, e);

        // R5: disable again
        cfg_write(6'd12, 4'b0001, 32'h0);
        mem_read(BASE + 32'h20, 2'd1, d, h);
        check("R5 re-disabled data", d, 32'h0000_FFFF);
        check("R5 re-disabled hit", {31'h0, h}, 32'h0);

        // R1: reset clears a programmed register
        cfg_write(6'd12, 4'hF, BASE | 32'h1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        cfg_read(6'd12, d);
        check("R1 reset clears", d, 32'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule